// File: doc/BRIEF.md
# LCD Row/Column Output Level Mapper

This block turns the scan state of a multiplexed dot-matrix LCD into per-pin drive selections. For each of 40 driver pins it picks one of six bias rails, encoded as a 3-bit level code, or leaves the pin undriven. The inputs are the current scan row, the frame polarity, the multiplex rate, the operating mode (row-only or mixed row/column), a blanking flag and one pixel bit per pin. The pins form five groups of eight. The first group always scans rows and the last group always carries column data. The three middle groups become rows or columns according to the rate and the mode.

At the two lowest rates the row pulse is copied onto several groups, so that split-screen panels are scanned in parallel. Polarity flips on odd frames so that the panel sees no net DC. Codes are registered and appear one clock after the inputs are sampled. The analog switch stage downstream uses each code to close one rail switch per pin.

Top module: `lcd_line_mapper`

## Requirements
- R1: While `rstN` is low, and until the first rising clock edge after it goes high, every `drvEn` bit is 0 and every level code is 0.
- R2: Outputs are registered. The codes and enables seen after a rising edge reflect the inputs sampled at that edge, and they do not change between edges.
- R3: Pins 0 to 7 are enabled rows in both modes. In mixed mode, pins 32 to 39 are enabled columns.
- R4: `muxSel` encodes the rate as 0 = 1:8, 1 = 1:16, 2 = 1:24 and 3 = 1:32, giving a row count n of 8, 16, 24 or 32. In mixed mode, pins 0 to n-1 are rows and pins n to 39 are columns.
- R5: In row mode (`mixedMode` = 0), pins 0 to 31 are rows at every rate. Pins 32 to 39 have `drvEn` = 0 and code 0.
- R6: A selected row drives code 0 (VDD) in even frames (`frameOdd` = 0) and code 5 (VLCD) in odd frames.
- R7: A row that is not selected drives code 4 (V5) in even frames and code 1 (V2) in odd frames.
- R8: The rate sets which rows are selected. At 1:32, pin p is selected when p equals `rowIdx`. At 1:16, pin p is selected when p mod 16 equals `rowIdx`. At 1:8, pin p is selected when p mod 8 equals `rowIdx`. Only pins that are rows can be selected.
- R9: At 1:24 the pulse is not copied, so only pin `rowIdx` is selected. At every rate, a `rowIdx` of n or more selects no pin.
- R10: A column pin p whose `colData[p]` is 1 drives code 5 (VLCD) in even frames and code 0 (VDD) in odd frames. When `colData[p]` is 0, the pin drives code 2 (V3) in even frames and code 3 (V4) in odd frames.
- R11: While `blank` is 1, every column drives its pixel-off code (2 in even frames, 3 in odd frames), whatever `colData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowIdx | input | 5 | Row currently being scanned |
| frameOdd | input | 1 | Frame polarity, 1 = odd frame |
| muxSel | input | 2 | Multiplex rate code |
| mixedMode | input | 1 | 1 = mixed row/column, 0 = row-only |
| blank | input | 1 | Forces all columns to the pixel-off level |
| colData | input | 40 | Pixel bit per pin, used only on column pins |
| levelOut | output | 120 | 3-bit rail code per pin; pin p occupies bits 3p+2..3p |
| drvEn | output | 40 | Per-pin drive enable, 0 = high impedance |

## Verification
A corrupted row/column role shows up one clock later as a wrong enable, or as the wrong family of codes: a row pin shows codes 0, 1, 4 or 5 in the row pattern, while a column pin shows a pixel-dependent code. A wrong group match for the row pulse moves or duplicates the select code onto the wrong pins in that same cycle. Comparing the whole 120-bit code vector for each stimulus catches this. A polarity or blanking error changes every affected pin in the very next sample. The copy across groups at 1:8 and 1:16, and its absence at 1:24, are checked pin-pair by pin-pair.

// File: rtl/lcdmap_pkg.sv
package lcdmap_pkg;
  localparam int NUM_OUT  = 40;
  localparam int GRP_SIZE = 8;
  localparam int NUM_GRP  = NUM_OUT / GRP_SIZE;
  localparam int GRP_LOG  = $clog2(GRP_SIZE);
  localparam int LVL_W    = 3;
  localparam int ROW_W    = 5;
  localparam int CNT_W    = ROW_W + 1;
  localparam int GSEL_W   = ROW_W - GRP_LOG;

  typedef enum logic [LVL_W-1:0] {
    LVL_VDD  = 3'd0,
    LVL_V2   = 3'd1,
    LVL_V3   = 3'd2,
    LVL_V4   = 3'd3,
    LVL_V5   = 3'd4,
    LVL_VLCD = 3'd5
  } level_e;

  typedef enum logic [1:0] {
    MUX_8  = 2'd0,
    MUX_16 = 2'd1,
    MUX_24 = 2'd2,
    MUX_32 = 2'd3
  } mux_e;

  typedef struct packed {
    logic [NUM_OUT-1:0] rowRole;
    logic [NUM_OUT-1:0] colRole;
    logic [NUM_OUT-1:0] rowHit;
    logic               oddFrame;
    logic               blankCols;
  } strobe_t;
endpackage

// File: rtl/lcdmap_ctrl.sv
module lcdmap_ctrl
  import lcdmap_pkg::*;
(
  input  logic [ROW_W-1:0] rowIdx,
  input  logic             frameOdd,
  input  logic [1:0]       muxSel,
  input  logic             mixedMode,
  input  logic             blank,
  output strobe_t          strb
);
  logic [CNT_W-1:0]   rowCount;
  logic               rowValid;
  logic [GRP_LOG-1:0] lowIdx;
  logic [GSEL_W-1:0]  grpIdx;
  logic [NUM_GRP-1:0] grpIsRow;
  logic [NUM_GRP-1:0] grpMatch;
  logic [NUM_OUT-1:0] rowRoleV;
  logic [NUM_OUT-1:0] colRoleV;
  logic [NUM_OUT-1:0] rowHitV;

  always_comb begin
    rowCount = (CNT_W'(muxSel) + CNT_W'(1)) << GRP_LOG;
    rowValid = {1'b0, rowIdx} < rowCount;
    lowIdx   = rowIdx[GRP_LOG-1:0];
    grpIdx   = rowIdx[ROW_W-1:GRP_LOG];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    localparam logic [CNT_W-1:0]  GBASE = CNT_W'(g * GRP_SIZE);
    localparam logic [GSEL_W-1:0] GSEL  = GSEL_W'(g);
    localparam bit                LAST  = (g == NUM_GRP - 1);

    // Last group never scans; in row-only mode every other group does.
    if (LAST) begin : gColOnly
      assign grpIsRow[g] = 1'b0;
    end else begin : gProg
      assign grpIsRow[g] = mixedMode ? (GBASE < rowCount) : 1'b1;
    end

    // Row-pulse copy: the rate picks how many groups share one select.
    always_comb begin
      unique case (mux_e'(muxSel))
        MUX_8:   grpMatch[g] = 1'b1;
        MUX_16:  grpMatch[g] = (grpIdx[0] == GSEL[0]);
        default: grpMatch[g] = (grpIdx == GSEL);
      endcase
    end

    for (genvar k = 0; k < GRP_SIZE; k++) begin : gPin
      localparam int                 IDX  = g * GRP_SIZE + k;
      localparam logic [GRP_LOG-1:0] KSEL = GRP_LOG'(k);
      assign rowRoleV[IDX] = grpIsRow[g];
      assign colRoleV[IDX] = mixedMode & ~grpIsRow[g];
      assign rowHitV[IDX]  = grpIsRow[g] & rowValid & grpMatch[g] & (lowIdx == KSEL);
    end
  end

  assign strb = '{rowRole:   rowRoleV,
                  colRole:   colRoleV,
                  rowHit:    rowHitV,
                  oddFrame:  frameOdd,
                  blankCols: blank};
endmodule

// File: rtl/lcdmap_dp.sv
module lcdmap_dp
  import lcdmap_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [NUM_OUT-1:0]       colData,
  output logic [NUM_OUT*LVL_W-1:0] levelOut,
  output logic [NUM_OUT-1:0]       drvEn
);
  logic [NUM_OUT*LVL_W-1:0] nxtLevel;
  logic [NUM_OUT-1:0]       nxtEn;
  logic [NUM_OUT-1:0]       pixOn;

  assign pixOn = colData & {NUM_OUT{~strb.blankCols}};
  assign nxtEn = strb.rowRole | strb.colRole;

  for (genvar i = 0; i < NUM_OUT; i++) begin : gLvl
    level_e rowLvl;
    level_e colLvl;
    always_comb begin
      if (strb.rowHit[i]) rowLvl = strb.oddFrame ? LVL_VLCD : LVL_VDD;
      else                rowLvl = strb.oddFrame ? LVL_V2   : LVL_V5;
      if (pixOn[i])       colLvl = strb.oddFrame ? LVL_VDD  : LVL_VLCD;
      else                colLvl = strb.oddFrame ? LVL_V4   : LVL_V3;
    end
    assign nxtLevel[i*LVL_W +: LVL_W] = strb.rowRole[i] ? rowLvl :
                                        strb.colRole[i] ? colLvl : LVL_VDD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelOut <= '0;
      drvEn    <= '0;
    end else begin
      levelOut <= nxtLevel;
      drvEn    <= nxtEn;
    end
  end
endmodule

// File: rtl/lcd_line_mapper.sv
module lcd_line_mapper
  import lcdmap_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ROW_W-1:0]         rowIdx,
  input  logic                     frameOdd,
  input  logic [1:0]               muxSel,
  input  logic                     mixedMode,
  input  logic                     blank,
  input  logic [NUM_OUT-1:0]       colData,
  output logic [NUM_OUT*LVL_W-1:0] levelOut,
  output logic [NUM_OUT-1:0]       drvEn
);
  strobe_t strb;

  lcdmap_ctrl uCtrl (
    .rowIdx    (rowIdx),
    .frameOdd  (frameOdd),
    .muxSel    (muxSel),
    .mixedMode (mixedMode),
    .blank     (blank),
    .strb      (strb)
  );

  lcdmap_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .colData  (colData),
    .levelOut (levelOut),
    .drvEn    (drvEn)
  );
endmodule

// File: rtl/lcd_line_mapper_chk.sv
module lcd_line_mapper_chk
  import lcdmap_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [1:0]               muxSel,
  input logic                     mixedMode,
  input logic                     blank,
  input logic [NUM_OUT*LVL_W-1:0] levelOut,
  input logic [NUM_OUT-1:0]       drvEn
);
  // R1: undriven while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_reset_hiz_r1: assert (drvEn == '0 && levelOut == '0);
    end
  end

  // R3: the first group is always an enabled row
  p_low_rows_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (&drvEn[GRP_SIZE-1:0]));

  // R3: the last group is enabled in mixed mode
  p_top_cols_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    mixedMode |=> (&drvEn[NUM_OUT-1:NUM_OUT-GRP_SIZE]));

  // R5: the last group floats in row-only mode
  p_rowmode_hiz_r5: assert property (@(posedge clk) disable iff (!rstN)
    !mixedMode |=> (drvEn[NUM_OUT-1:NUM_OUT-GRP_SIZE] == '0 &&
                    levelOut[NUM_OUT*LVL_W-1:(NUM_OUT-GRP_SIZE)*LVL_W] == '0));

  // R8: pin 0 and pin 16 carry the same code at 1:16 in row mode
  p_split_pair_r8: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel == 2'd1 && !mixedMode) |=>
      (levelOut[0 +: LVL_W] == levelOut[16*LVL_W +: LVL_W]));

  // R8: pin 0 and pin 24 carry the same code at 1:8 in row mode
  p_quad_copy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel == 2'd0 && !mixedMode) |=>
      (levelOut[0 +: LVL_W] == levelOut[24*LVL_W +: LVL_W]));

  // R11: blanked top column shows only pixel-off codes
  p_blank_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mixedMode && blank) |=>
      (levelOut[(NUM_OUT-1)*LVL_W +: LVL_W] == LVL_V3 ||
       levelOut[(NUM_OUT-1)*LVL_W +: LVL_W] == LVL_V4));
endmodule

bind lcd_line_mapper lcd_line_mapper_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .muxSel    (muxSel),
  .mixedMode (mixedMode),
  .blank     (blank),
  .levelOut  (levelOut),
  .drvEn     (drvEn)
);

// File: tb/lcd_line_mapper_test.sv
`timescale 1ns/1ps
module lcd_line_mapper_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [4:0]   rowIdx = '0;
  logic         frameOdd = 1'b0;
  logic [1:0]   muxSel = 2'd3;
  logic         mixedMode = 1'b0;
  logic         blank = 1'b1;
  logic [39:0]  colData = '0;
  logic [119:0] levelOut;
  logic [39:0]  drvEn;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lcd_line_mapper uut (
    .clk(clk), .rstN(rstN), .rowIdx(rowIdx), .frameOdd(frameOdd),
    .muxSel(muxSel), .mixedMode(mixedMode), .blank(blank),
    .colData(colData), .levelOut(levelOut), .drvEn(drvEn)
  );

  typedef struct packed {
    logic [4:0]  r;
    logic        odd;
    logic [1:0]  m;
    logic        mix;
    logic        blk;
    logic [39:0] cd;
    logic [5:0]  expEn;   // expected number of driven pins
    logic [3:0]  tag;     // requirement number reported on failure
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd5,  1'b0, 2'd3, 1'b0, 1'b0, 40'h0,            6'd32, 4'd6},  // R6 R7 R5
    '{5'd31, 1'b1, 2'd3, 1'b0, 1'b0, 40'hFF_FFFF_FFFF, 6'd32, 4'd6},  // R6 odd
    '{5'd3,  1'b0, 2'd0, 1'b0, 1'b0, 40'h0,            6'd32, 4'd8},  // R8 1:8 x4
    '{5'd9,  1'b1, 2'd1, 1'b0, 1'b0, 40'h0,            6'd32, 4'd8},  // R8 1:16 x2
    '{5'd2,  1'b0, 2'd2, 1'b0, 1'b0, 40'h0,            6'd32, 4'd9},  // R9 no copy
    '{5'd27, 1'b1, 2'd2, 1'b0, 1'b0, 40'h0,            6'd32, 4'd9},  // R9 out of range
    '{5'd3,  1'b0, 2'd0, 1'b1, 1'b0, 40'hA5_3C_F0_0F_96, 6'd40, 4'd4},  // R4 R10
    '{5'd15, 1'b1, 2'd1, 1'b1, 1'b0, 40'h5A_C3_0F_F0_69, 6'd40, 4'd10}, // R10 odd
    '{5'd0,  1'b0, 2'd2, 1'b1, 1'b1, 40'hFF_FFFF_FFFF, 6'd40, 4'd11}, // R11 even
    '{5'd31, 1'b0, 2'd3, 1'b1, 1'b0, 40'hFF_0000_0000, 6'd40, 4'd3},  // R3 top cols
    '{5'd12, 1'b1, 2'd0, 1'b1, 1'b0, 40'h12_3456_789A, 6'd40, 4'd9},  // R9 mixed
    '{5'd20, 1'b1, 2'd1, 1'b1, 1'b1, 40'hFF_FFFF_FFFF, 6'd40, 4'd11}  // R11 odd
  };

  function automatic string reqName(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  // Reference built from the requirement text, pin by pin.
  function automatic void model(input logic [4:0] r, input logic odd,
                                input logic [1:0] m, input logic mix,
                                input logic blk, input logic [39:0] cd,
                                output logic [119:0] lv, output logic [39:0] en);
    int n;
    n = 8 * (int'(m) + 1);
    lv = '0;
    en = '0;
    for (int p = 0; p < 40; p++) begin
      bit isRow, isCol, sel;
      logic [2:0] c;
      isRow = mix ? (p < n) : (p < 32);
      isCol = mix && !isRow;
      if (m >= 2'd2) sel = isRow && (int'(r) < n) && (p == int'(r));
      else           sel = isRow && (int'(r) < n) && ((p % n) == int'(r));
      c = 3'd0;
      if (isRow)      c = sel ? (odd ? 3'd5 : 3'd0) : (odd ? 3'd1 : 3'd4);
      else if (isCol) c = (cd[p] && !blk) ? (odd ? 3'd0 : 3'd5) : (odd ? 3'd3 : 3'd2);
      lv[p*3 +: 3] = c;
      en[p] = isRow || isCol;
    end
  endfunction

  task automatic check(input string req, input logic [119:0] act, input logic [119:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rowIdx = v.r; frameOdd = v.odd; muxSel = v.m;
    mixedMode = v.mix; blank = v.blk; colData = v.cd;
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [119:0] eLv, pLv;
    logic [39:0]  eEn, pEn;

    // R1: reset state while held and before the first edge after release
    @(negedge clk);
    check("R1", {80'h0, drvEn}, 120'h0);
    check("R1", levelOut, 120'h0);
    rstN = 1'b1;
    #1;
    check("R1", {80'h0, drvEn}, 120'h0);

    // Vector walk (R3..R11)
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VECS[k]);
      @(negedge clk);
      model(VECS[k].r, VECS[k].odd, VECS[k].m, VECS[k].mix, VECS[k].blk,
            VECS[k].cd, eLv, eEn);
      check(reqName(int'(VECS[k].tag)), levelOut, eLv);
      check(reqName(int'(VECS[k].tag)), {80'h0, drvEn}, {80'h0, eEn});
      check(reqName(int'(VECS[k].tag)), 120'($countones(drvEn)), 120'(VECS[k].expEn));
    end

    // R2: no change before the edge, new value after it
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    model(VECS[0].r, VECS[0].odd, VECS[0].m, VECS[0].mix, VECS[0].blk,
          VECS[0].cd, pLv, pEn);
    drive(VECS[6]);
    #2;
    check("R2", levelOut, pLv);
    check("R2", {80'h0, drvEn}, {80'h0, pEn});
    @(negedge clk);
    model(VECS[6].r, VECS[6].odd, VECS[6].m, VECS[6].mix, VECS[6].blk,
          VECS[6].cd, eLv, eEn);
    check("R2", levelOut, eLv);

    // R11 vs R10: same pixels, blank toggled, in odd frame at 1:32 mixed
    @(negedge clk);
    rowIdx = 5'd0; frameOdd = 1'b1; muxSel = 2'd3; mixedMode = 1'b1;
    colData = 40'hFF_0000_0000; blank = 1'b0;
    @(negedge clk);
    check("R10", {117'h0, levelOut[119:117]}, 120'd0);
    blank = 1'b1;
    @(negedge clk);
    check("R11", {117'h0, levelOut[119:117]}, 120'd3);

    // R7: out-of-range row in even frame leaves all rows at V5 (code 4)
    @(negedge clk);
    rowIdx = 5'd31; frameOdd = 1'b0; muxSel = 2'd2; mixedMode = 1'b0; blank = 1'b0;
    @(negedge clk);
    check("R7", {117'h0, levelOut[3*23 +: 3]}, 120'd4);
    check("R7", {117'h0, levelOut[3*31 +: 3]}, 120'd4);

    // R1: asynchronous reset mid-run floats every pin at once
    #2;
    rstN = 1'b0;
    #1;
    check("R1", {80'h0, drvEn}, 120'h0);
    check("R1", levelOut, 120'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    model(5'd31, 1'b0, 2'd2, 1'b0, 1'b0, 40'h0, eLv, eEn);
    check("R5", levelOut, eLv);

    finishRun();
  end
endmodule